// File: doc/BRIEF.md
# Link Bootstrap Loader Controller

This controller runs once after reset and decides where the processor starts executing. A select input is sampled while reset is held. It chooses one of two boot modes: boot from the fixed ROM entry, or boot from a program image that arrives over one of several byte links. In ROM mode the controller issues a single jump request to the entry word at the top of the address space, and nothing else happens.

In link mode the controller watches every link and locks onto the first one that presents a byte. That first byte is a length, from 0 to 255. The controller then accepts exactly that many further bytes from the chosen link only. It writes them through a byte-wide memory write port to ascending addresses, starting at a fixed load address. After the last byte it pulses a start request that carries the load address.

The other links are never handshaken. Their bytes stay pending for software to collect later. Each link is a valid/ack pair, and a byte moves on a clock edge where both valid and ack are high.

Top module: `boot_loader_ctrl`

## Requirements
- R1: The mode input `boot_from_link` is sampled on every clock edge while `rst_n` is low and ignored afterwards. While reset is held, `link_ack`, `mem_we`, `go_link`, `go_rom` and `boot_done` are all 0.
- R2: In ROM mode (sampled value 0), `go_rom` is high for exactly one cycle. This is the second cycle after reset release. In that cycle `go_addr` is 2^ADDR_W-2 (0xFFFE by default) and `boot_done` rises. No link is ever acknowledged.
- R3: In link mode (sampled value 1), the first link that raises `link_valid` after the first post-reset cycle is acknowledged. Its byte is taken as the image length. A lower-numbered link that becomes valid later does not take over.
- R4: If several links become valid in the same cycle while the length is awaited, only the lowest-numbered of them is acknowledged.
- R5: At most one `link_ack` bit is high in any cycle. Once a link has won, only that link is acknowledged.
- R6: Each accepted image byte drives `mem_we` high in the cycle of its handshake. The byte's value is on `mem_wdata`. The i-th byte (i from 0) goes to address LOAD_ADDR+i (0x0200 by default).
- R7: The cycle after the last image byte is accepted, `go_link` is high for one cycle, `go_addr` equals LOAD_ADDR, and `boot_done` rises.
- R8: A length byte of 0 gives `go_link` and `boot_done` in the cycle after the length handshake, with no memory write.
- R9: Once `boot_done` is high it stays high until reset. After that, no link is acknowledged and no memory write occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| boot_from_link | input | 1 | Boot mode select, sampled during reset (1 = link, 0 = ROM) |
| link_valid | input | N_LINKS | Per-link byte available |
| link_data | input | 8*N_LINKS | Per-link byte, link k in bits 8k+7:8k |
| link_ack | output | N_LINKS | Per-link byte accepted |
| mem_we | output | 1 | Memory byte write strobe |
| mem_addr | output | ADDR_W | Memory write address |
| mem_wdata | output | 8 | Memory write byte |
| go_link | output | 1 | One-cycle start request after a link load |
| go_rom | output | 1 | One-cycle jump request to the ROM entry |
| go_addr | output | ADDR_W | Target address of the start or jump request |
| boot_done | output | 1 | Boot sequence finished |

## Verification
The length-wait stage can see a first arrival on two links in the same cycle. This happens when links 1 and 3 are both raised in the cycle the bench drives, and it is judged by which link gets the acknowledge. A second collision pairs the last image handshake with start issue and loader shutdown. While the chosen link delivers its final byte, the losing links keep valid high throughout. The bench model then expects the write, the one-cycle start pulse and a silent `link_ack` from then on. Every clock, the behavioural model is compared with the acknowledges, the write port and the start signals.

// File: rtl/boot_ldr_pkg.sv
package boot_ldr_pkg;
  typedef enum logic [1:0] {
    PH_BOOT = 2'd0,
    PH_LEN  = 2'd1,
    PH_BODY = 2'd2,
    PH_DONE = 2'd3
  } phase_t;
endpackage

// File: rtl/boot_first_pick.sv
module boot_first_pick #(
  parameter int N_REQ = 4,
  localparam int IDX_W = (N_REQ > 1) ? $clog2(N_REQ) : 1
) (
  input  logic [N_REQ-1:0] req,
  output logic [N_REQ-1:0] grant,
  output logic [IDX_W-1:0] idx,
  output logic             any
);
  function automatic logic [IDX_W-1:0] lowest_set(input logic [N_REQ-1:0] v);
    logic [IDX_W-1:0] r;
    r = '0;
    for (int k = N_REQ - 1; k >= 0; k--) begin
      if (v[k]) r = IDX_W'(k);
    end
    return r;
  endfunction

  assign any   = |req;
  assign idx   = lowest_set(req);
  assign grant = any ? (N_REQ'(1) << idx) : '0;
endmodule

// File: rtl/boot_load_counter.sv
module boot_load_counter #(
  parameter int ADDR_W = 16,
  parameter int LEN_W  = 8,
  parameter logic [ADDR_W-1:0] BASE = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [LEN_W-1:0]  len,
  input  logic              step,
  output logic [ADDR_W-1:0] addr,
  output logic              last
);
  logic [LEN_W-1:0]  left_q;
  logic [ADDR_W-1:0] addr_q;

  function automatic logic [ADDR_W-1:0] bump(input logic [ADDR_W-1:0] a);
    return a + ADDR_W'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      left_q <= '0;
      addr_q <= BASE;
    end else if (load) begin
      left_q <= len;
      addr_q <= BASE;
    end else if (step) begin
      left_q <= left_q - LEN_W'(1);
      addr_q <= bump(addr_q);
    end
  end

  assign addr = addr_q;
  assign last = (left_q == LEN_W'(1));

  assert_no_underflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
    step |-> (left_q != '0));
endmodule

// File: rtl/boot_loader_ctrl.sv
module boot_loader_ctrl #(
  parameter int N_LINKS = 4,
  parameter int ADDR_W  = 16,
  parameter logic [ADDR_W-1:0] LOAD_ADDR = 16'h0200,
  localparam int IDX_W = (N_LINKS > 1) ? $clog2(N_LINKS) : 1,
  localparam logic [ADDR_W-1:0] ROM_ENTRY = {{(ADDR_W-1){1'b1}}, 1'b0}
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 boot_from_link,
  input  logic [N_LINKS-1:0]   link_valid,
  input  logic [8*N_LINKS-1:0] link_data,
  output logic [N_LINKS-1:0]   link_ack,
  output logic                 mem_we,
  output logic [ADDR_W-1:0]    mem_addr,
  output logic [7:0]           mem_wdata,
  output logic                 go_link,
  output logic                 go_rom,
  output logic [ADDR_W-1:0]    go_addr,
  output logic                 boot_done
);
  import boot_ldr_pkg::*;

  phase_t           phase_q;
  logic             mode_q;
  logic [IDX_W-1:0] owner_q;
  logic             go_link_q, go_rom_q, done_q;

  logic [N_LINKS-1:0] first_grant;
  logic [IDX_W-1:0]   first_idx;
  logic               first_any;
  logic [7:0]         len_byte;
  logic               len_take, body_take, last_byte;
  logic               owner_valid;

  boot_first_pick #(.N_REQ(N_LINKS)) u_pick (
    .req(link_valid), .grant(first_grant), .idx(first_idx), .any(first_any)
  );

  assign len_byte    = link_data[int'(first_idx)*8 +: 8];
  assign owner_valid = link_valid[owner_q];
  assign len_take    = (phase_q == PH_LEN) && first_any;
  assign body_take   = (phase_q == PH_BODY) && owner_valid;

  boot_load_counter #(.ADDR_W(ADDR_W), .LEN_W(8), .BASE(LOAD_ADDR)) u_cnt (
    .clk(clk), .rst_n(rst_n), .load(len_take), .len(len_byte),
    .step(body_take), .addr(mem_addr), .last(last_byte)
  );

  always_comb begin
    link_ack = '0;
    if (len_take)  link_ack = first_grant;
    if (body_take) link_ack = N_LINKS'(1) << owner_q;
  end

  assign mem_we    = body_take;
  assign mem_wdata = link_data[int'(owner_q)*8 +: 8];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q    <= boot_from_link;
      phase_q   <= PH_BOOT;
      owner_q   <= '0;
      go_link_q <= 1'b0;
      go_rom_q  <= 1'b0;
      done_q    <= 1'b0;
    end else begin
      go_link_q <= 1'b0;
      go_rom_q  <= 1'b0;
      unique case (phase_q)
        PH_BOOT: begin
          if (mode_q) phase_q <= PH_LEN;
          else begin
            go_rom_q <= 1'b1;
            done_q   <= 1'b1;
            phase_q  <= PH_DONE;
          end
        end
        PH_LEN: begin
          if (len_take) begin
            owner_q <= first_idx;
            if (len_byte == 8'd0) begin
              go_link_q <= 1'b1;
              done_q    <= 1'b1;
              phase_q   <= PH_DONE;
            end else phase_q <= PH_BODY;
          end
        end
        PH_BODY: begin
          if (body_take && last_byte) begin
            go_link_q <= 1'b1;
            done_q    <= 1'b1;
            phase_q   <= PH_DONE;
          end
        end
        default: ;
      endcase
    end
  end

  assign go_link   = go_link_q;
  assign go_rom    = go_rom_q;
  assign boot_done = done_q;
  assign go_addr   = mode_q ? LOAD_ADDR : ROM_ENTRY;

  assert_ack_onehot_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(link_ack));
  assert_ack_in_valid_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (link_ack & ~link_valid) == '0);
  assert_write_acked_R5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> link_ack[owner_q]);
  assert_addr_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> (!mem_we || mem_addr == $past(mem_addr) + ADDR_W'(1)));
  assert_go_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    go_link |=> !go_link);
  assert_go_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
    go_link |-> ($rose(boot_done) && go_addr == LOAD_ADDR));
  assert_rom_mode_R2: assert property (@(posedge clk) disable iff (!rst_n)
    go_rom |-> (!mode_q && go_addr == ROM_ENTRY));
  assert_done_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    boot_done |=> boot_done);
  assert_quiet_after_R9: assert property (@(posedge clk) disable iff (!rst_n)
    boot_done |-> (link_ack == '0 && !mem_we));
endmodule

// File: tb/test_boot_loader_ctrl.sv
`timescale 1ns/1ps
module test_boot_loader_ctrl;
  localparam int NL = 4;
  localparam int LOAD = 'h0200;
  localparam int ROMA = 'hFFFE;

  logic clk = 0;
  logic rst_n = 0;
  logic bfl = 0;
  logic [NL-1:0] drv_valid = '0;
  logic [7:0] drv_data [NL];
  logic [8*NL-1:0] link_data;
  logic [NL-1:0] link_ack;
  logic mem_we, go_link, go_rom, boot_done;
  logic [15:0] mem_addr, go_addr;
  logic [7:0] mem_wdata;

  always #4 clk = ~clk;
  assign link_data = {drv_data[3], drv_data[2], drv_data[1], drv_data[0]};

  boot_loader_ctrl i_boot_loader_ctrl (
    .clk(clk), .rst_n(rst_n), .boot_from_link(bfl), .link_valid(drv_valid),
    .link_data(link_data), .link_ack(link_ack), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .go_link(go_link),
    .go_rom(go_rom), .go_addr(go_addr), .boot_done(boot_done)
  );

  int tests = 0, fails = 0;
  bit armed = 0;
  int m_mode = 0, m_ph = 0, m_own = 0, m_left = 0, m_next = 0;
  int m_gl = 0, m_gr = 0, m_dn = 0;
  int n_wr = 0, n_gl = 0, n_gr = 0, first_acked = -1;
  byte unsigned img [int];

  task automatic chk(string tag, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int first_valid(logic [NL-1:0] v);
    int k = 0;
    while (k < NL && !v[k]) k++;
    return (k < NL) ? k : -1;
  endfunction

  always @(negedge clk) begin
    int ea, ewe, w;
    if (armed) begin
      ea = 0; ewe = 0;
      if (m_ph == 1) begin
        w = first_valid(drv_valid);
        if (w >= 0) ea = 1 << w;
      end else if (m_ph == 2 && drv_valid[m_own]) begin
        ea = 1 << m_own; ewe = 1;
      end
      tests++;
      if (link_ack != ea[NL-1:0] || mem_we != ewe[0] ||
          (ewe != 0 && (mem_addr != m_next[15:0] || mem_wdata != drv_data[m_own])) ||
          go_link != m_gl[0] || go_rom != m_gr[0] || boot_done != m_dn[0] ||
          (rst_n && go_addr != (m_mode ? LOAD : ROMA))) begin
        fails++;
        $display("FAIL R5/R6/R7/R2 cycle model ack=%0h/%0h we=%0d/%0d addr=%0h/%0h go=%0d%0d/%0d%0d done=%0d/%0d",
                 link_ack, ea, mem_we, ewe, mem_addr, m_next, go_link, go_rom, m_gl, m_gr, boot_done, m_dn);
      end
    end
    if (rst_n) begin
      if (mem_we) begin img[int'(mem_addr)] = mem_wdata; n_wr++; end
      if (go_link) n_gl++;
      if (go_rom) n_gr++;
      if (link_ack != 0 && first_acked < 0) first_acked = first_valid(link_ack);
    end
    // model register update for the coming edge
    if (!rst_n) begin
      m_mode = bfl; m_ph = 0; m_gl = 0; m_gr = 0; m_dn = 0;
    end else begin
      m_gl = 0; m_gr = 0;
      if (m_ph == 0) begin
        if (m_mode == 0) begin m_gr = 1; m_dn = 1; m_ph = 3; end
        else m_ph = 1;
      end else if (m_ph == 1) begin
        w = first_valid(drv_valid);
        if (w >= 0) begin
          m_own = w; m_left = drv_data[w]; m_next = LOAD;
          if (m_left == 0) begin m_gl = 1; m_dn = 1; m_ph = 3; end
          else m_ph = 2;
        end
      end else if (m_ph == 2 && drv_valid[m_own]) begin
        m_next++; m_left--;
        if (m_left == 0) begin m_gl = 1; m_dn = 1; m_ph = 3; end
      end
    end
  end

  always @(posedge clk) armed <= 1;

  task automatic do_reset(bit mode);
    drv_valid = '0;
    rst_n = 0; bfl = mode;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 idle during reset", {link_ack, mem_we, go_link, go_rom, boot_done}, 0);
    n_wr = 0; n_gl = 0; n_gr = 0; first_acked = -1; img.delete();
    rst_n = 1;
    bfl = ~mode;   // must be ignored from here on
  endtask

  task automatic push(int l, byte unsigned v);
    drv_valid[l] = 1; drv_data[l] = v;
    do @(negedge clk); while (!link_ack[l]);
    @(posedge clk); #1;
    drv_valid[l] = 0;
  endtask

  task automatic finish_run();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++; tests++;
    $display("FAIL watchdog: run did not end, actual=hung expected=done");
    finish_run();
  end

  initial begin
    for (int k = 0; k < NL; k++) drv_data[k] = 8'h00;
    // ROM boot, mode flipped after reset, links active
    do_reset(1'b0);
    drv_valid = 4'b1111;
    repeat (10) @(posedge clk);
    #1;
    chk("R2 rom jump count", n_gr, 1);
    chk("R1 no link start in rom mode", n_gl, 0);
    chk("R2 no ack in rom mode", first_acked, -1);
    chk("R9 done held", boot_done, 1);

    // link 2 first, lower links arrive later
    do_reset(1'b1);
    repeat (2) @(posedge clk); #1;
    push(2, 8'd5);
    drv_valid[0] = 1; drv_data[0] = 8'hAA;
    drv_valid[1] = 1; drv_data[1] = 8'hBB;
    for (int i = 0; i < 5; i++) begin
      push(2, byte'(8'h30 + i));
      if (i == 2) repeat (3) @(posedge clk);
      #1;
    end
    repeat (6) @(posedge clk); #1;
    chk("R3 first arrival owns boot", first_acked, 2);
    chk("R6 write count", n_wr, 5);
    for (int i = 0; i < 5; i++)
      chk("R6 image byte", img.exists(LOAD + i) ? int'(img[LOAD + i]) : -1, 8'h30 + i);
    chk("R7 single start", n_gl, 1);
    chk("R9 losers never acked", link_ack, 0);

    // simultaneous arrival on 1 and 3
    do_reset(1'b1);
    @(posedge clk); #1;
    drv_valid[3] = 1; drv_data[3] = 8'd3;
    push(1, 8'd3);
    chk("R4 lowest index wins tie", first_acked, 1);
    for (int i = 0; i < 3; i++) push(1, byte'(8'hC0 + i));
    repeat (3) @(posedge clk); #1;
    chk("R4 write count", n_wr, 3);
    chk("R6 last byte", img.exists(LOAD + 2) ? int'(img[LOAD + 2]) : -1, 8'hC2);

    // zero length
    do_reset(1'b1);
    @(posedge clk); #1;
    push(3, 8'd0);
    @(negedge clk);
    chk("R8 start after empty image", go_link, 1);
    chk("R8 start address", go_addr, LOAD);
    repeat (4) @(posedge clk); #1;
    chk("R8 no writes", n_wr, 0);

    // full 255-byte image, continuous
    do_reset(1'b1);
    push(0, 8'd255);
    for (int i = 0; i < 255; i++) push(0, byte'(i ^ 8'h5A));
    repeat (3) @(posedge clk); #1;
    chk("R6 full image count", n_wr, 255);
    chk("R6 top address byte", img.exists(LOAD + 254) ? int'(img[LOAD + 254]) : -1, 254 ^ 8'h5A);
    chk("R7 start count", n_gl, 1);
    finish_run();
  end
endmodule